// File: doc/BRIEF.md
# GPIO Bank with Edge-Triggered Interrupts

This block is one bank of general-purpose pins placed behind a plain 32-bit register bus. Software drives pins by making them outputs and setting or clearing their output data. It reads the pin levels through a synchronized input register. It can also arm each pin to raise an interrupt on a rising transition, a falling transition or both. Captured edges collect in a pending register. One interrupt line is asserted while any pending bit is set. Software clears pending bits by writing ones to them.

Output data and direction never take a full-word write. They change only through separate set and clear aliases, so two agents that touch different pins need no read-modify-write. The bus is single-cycle: a write takes effect at the clock edge that samples it, and read data is combinational from the selected address.

Top module: `gpio_edge_bank`

## Requirements
- R1: Pin n maps to bit n of every register. Addresses outside the map read as zero, and writes to them change nothing. When `busSel` is low, `busRdata` is zero.
- R2: Offset 0x00 returns the pad levels after a two-flop synchronizer. A pad change sampled at clock edge k is readable after edge k+1. Writes to 0x00 are ignored.
- R3: Writing to 0x14 sets the output-data bits written as 1, and writing to 0x18 clears them. All other bits keep their value. Output data drives `padOut`.
- R4: Writing to 0x1C sets the direction bits written as 1, and writing to 0x20 clears them. Offset 0x04 reads the direction, where 1 means drive. Writes to 0x04 are ignored. Direction drives `padOe`.
- R5: Offset 0x28 holds the per-pin rising-edge enable and offset 0x2C holds the falling-edge enable. Both are plain read/write registers and are independent of each other.
- R6: A synchronized 0-to-1 transition sets the pin's pending bit only when its rising enable is 1. A 1-to-0 transition does so only when its falling enable is 1. With both enables set, either transition sets the bit. The pending bit is set at the second edge after the one that sampled the pad change.
- R7: Offset 0x0C reads the pending bits. Writing a mask there clears the bits written as 1, and bits written as 0 keep their value.
- R8: `irqOut` is high exactly while at least one pending bit is set.
- R9: If a new enabled edge and a pending clear for the same bit fall in the same cycle, the bit stays pending.
- R10: Reset clears output data, direction, both enables and pending.
- R11: Detection is edge-only. A pad held at a steady level does not set its pending bit again after it has been cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte offset of the register |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data, combinational |
| padIn | input | PIN_COUNT | Asynchronous pad levels |
| padOut | output | PIN_COUNT | Output data to pads |
| padOe | output | PIN_COUNT | Per-pin drive enable |
| irqOut | output | 1 | Combined interrupt request |

## Verification
The bench builds the bank with its default values: 32 pins, a 32-bit data bus and an 8-bit address. With these values every pin bit, including bit 31, and every decoded and undecoded offset is reachable through ordinary bus accesses. Directed sequences place a pending clear on the exact cycle an edge lands, hold a pad steady after a clear, and arm both edges on one pin. A long random phase then mixes pad toggles with writes to every offset. Throughout, a behavioural model tracks the two-stage input delay and is compared with the pads, the interrupt and the read data on every clock.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  // Register offsets: software decodes these, so they are fixed
  localparam logic [7:0] OFS_IN      = 8'h00;
  localparam logic [7:0] OFS_OE      = 8'h04;
  localparam logic [7:0] OFS_PEND    = 8'h0C;
  localparam logic [7:0] OFS_OUT_SET = 8'h14;
  localparam logic [7:0] OFS_OUT_CLR = 8'h18;
  localparam logic [7:0] OFS_OE_SET  = 8'h1C;
  localparam logic [7:0] OFS_OE_CLR  = 8'h20;
  localparam logic [7:0] OFS_RISE    = 8'h28;
  localparam logic [7:0] OFS_FALL    = 8'h2C;

  typedef enum logic [2:0] {
    RD_NONE, RD_IN, RD_OE, RD_PEND, RD_RISE, RD_FALL
  } rd_sel_e;

  // Strobes from the decoder into the register datapath
  typedef struct packed {
    logic    setOut;
    logic    clrOut;
    logic    setOe;
    logic    clrOe;
    logic    wrRise;
    logic    wrFall;
    logic    clrPend;
    rd_sel_e rdSel;
  } bank_stb_t;

endpackage

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output bank_stb_t         stb
);

  logic wrEn;
  assign wrEn = busSel & busWrite;

  always_comb begin
    stb = '0;
    stb.rdSel = RD_NONE;
    if (busSel) begin
      case (busAddr)
        ADDR_W'(OFS_IN):      stb.rdSel   = RD_IN;
        ADDR_W'(OFS_OE):      stb.rdSel   = RD_OE;
        ADDR_W'(OFS_PEND): begin
          stb.rdSel   = RD_PEND;
          stb.clrPend = wrEn;
        end
        ADDR_W'(OFS_OUT_SET): stb.setOut  = wrEn;
        ADDR_W'(OFS_OUT_CLR): stb.clrOut  = wrEn;
        ADDR_W'(OFS_OE_SET):  stb.setOe   = wrEn;
        ADDR_W'(OFS_OE_CLR):  stb.clrOe   = wrEn;
        ADDR_W'(OFS_RISE): begin
          stb.rdSel  = RD_RISE;
          stb.wrRise = wrEn;
        end
        ADDR_W'(OFS_FALL): begin
          stb.rdSel  = RD_FALL;
          stb.wrFall = wrEn;
        end
        default: stb.rdSel = RD_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int PIN_COUNT = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] syncVal,
  output logic [PIN_COUNT-1:0] riseEv,
  output logic [PIN_COUNT-1:0] fallEv
);

  localparam int STAGES = 3; // two sync flops plus one history flop

  for (genvar p = 0; p < PIN_COUNT; p++) begin : g_pin
    logic [STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= '0;
      else       stg <= {stg[STAGES-2:0], padIn[p]};
    end
    assign syncVal[p] = stg[1];
    assign riseEv[p]  = stg[1] & ~stg[2];
    assign fallEv[p]  = ~stg[1] & stg[2];
  end

endmodule

// File: rtl/gpio_edge_dpath.sv
module gpio_edge_dpath
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bank_stb_t            stb,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [PIN_COUNT-1:0] syncVal,
  input  logic [PIN_COUNT-1:0] riseEv,
  input  logic [PIN_COUNT-1:0] fallEv,
  output logic [DATA_W-1:0]    rdata,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);

  logic [PIN_COUNT-1:0] wMask;
  logic [PIN_COUNT-1:0] outQ, oeQ, riseEnQ, fallEnQ, pendQ;
  logic [PIN_COUNT-1:0] pendD;

  assign wMask = PIN_COUNT'(wdata);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outQ    <= '0;
      oeQ     <= '0;
      riseEnQ <= '0;
      fallEnQ <= '0;
    end else begin
      if (stb.setOut)      outQ <= outQ | wMask;
      else if (stb.clrOut) outQ <= outQ & ~wMask;
      if (stb.setOe)       oeQ  <= oeQ | wMask;
      else if (stb.clrOe)  oeQ  <= oeQ & ~wMask;
      if (stb.wrRise)      riseEnQ <= wMask;
      if (stb.wrFall)      fallEnQ <= wMask;
    end
  end

  // New edges are ORed in after the clear, so they win
  always_comb begin
    pendD = pendQ;
    if (stb.clrPend) pendD = pendD & ~wMask;
    pendD = pendD | (riseEv & riseEnQ) | (fallEv & fallEnQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendD;
  end

  always_comb begin
    case (stb.rdSel)
      RD_IN:   rdata = DATA_W'(syncVal);
      RD_OE:   rdata = DATA_W'(oeQ);
      RD_PEND: rdata = DATA_W'(pendQ);
      RD_RISE: rdata = DATA_W'(riseEnQ);
      RD_FALL: rdata = DATA_W'(fallEnQ);
      default: rdata = '0;
    endcase
  end

  assign padOut = outQ;
  assign padOe  = oeQ;
  assign irqOut = |pendQ;

endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busSel,
  input  logic                 busWrite,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic                 irqOut
);

  bank_stb_t            stb;
  logic [PIN_COUNT-1:0] syncVal, riseEv, fallEv;

  gpio_edge_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busSel  (busSel),
    .busWrite(busWrite),
    .busAddr (busAddr),
    .stb     (stb)
  );

  gpio_edge_sync #(.PIN_COUNT(PIN_COUNT)) sync_i (
    .clk    (clk),
    .rstN   (rstN),
    .padIn  (padIn),
    .syncVal(syncVal),
    .riseEv (riseEv),
    .fallEv (fallEv)
  );

  gpio_edge_dpath #(.PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wdata  (busWdata),
    .syncVal(syncVal),
    .riseEv (riseEv),
    .fallEv (fallEv),
    .rdata  (busRdata),
    .padOut (padOut),
    .padOe  (padOe),
    .irqOut (irqOut)
  );

endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int PIN_COUNT = 32,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 busSel,
  input logic                 busWrite,
  input logic [ADDR_W-1:0]    busAddr,
  input logic [DATA_W-1:0]    busWdata,
  input logic [PIN_COUNT-1:0] padOut,
  input logic [PIN_COUNT-1:0] padOe,
  input logic                 irqOut
);

  logic                 wr;
  logic [PIN_COUNT-1:0] wd;
  assign wr = busSel & busWrite;
  assign wd = PIN_COUNT'(busWdata);

  // R10: outputs are zero while reset is held
  always @(negedge clk) begin
    if (!rstN) begin
      a_r10_reset_zero: assert (padOut == '0 && padOe == '0 && !irqOut);
    end
  end

  // R3: output data moves only on a set or clear write
  a_r3_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wr && (busAddr == ADDR_W'(OFS_OUT_SET) || busAddr == ADDR_W'(OFS_OUT_CLR)))
    |=> $stable(padOut));

  // R3: bits written to the set alias are high afterwards
  a_r3_set_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(OFS_OUT_SET))
    |=> ((padOut & $past(wd)) == $past(wd)));

  // R4: direction moves only on a set or clear write
  a_r4_oe_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wr && (busAddr == ADDR_W'(OFS_OE_SET) || busAddr == ADDR_W'(OFS_OE_CLR)))
    |=> $stable(padOe));

  // R4: bits written to the clear alias are low afterwards
  a_r4_clr_takes: assert property (@(posedge clk) disable iff (!rstN)
    (wr && busAddr == ADDR_W'(OFS_OE_CLR))
    |=> ((padOe & $past(wd)) == '0));

  // R7: the interrupt drops only after a write to the pending register
  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(wr && busAddr == ADDR_W'(OFS_PEND)));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(
  .PIN_COUNT(PIN_COUNT), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .busSel  (busSel),
  .busWrite(busWrite),
  .busAddr (busAddr),
  .busWdata(busWdata),
  .padOut  (padOut),
  .padOe   (padOe),
  .irqOut  (irqOut)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb_top;

  localparam int PINS = 32;
  localparam int DW   = 32;
  localparam int AW   = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          busSel = 1'b0;
  logic          busWrite = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busWdata = '0;
  logic [DW-1:0] busRdata;
  logic [PINS-1:0] padIn = '0;
  logic [PINS-1:0] padOut, padOe;
  logic          irqOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_edge_bank #(.PIN_COUNT(PINS), .DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  // ---------------- behavioural reference ----------------
  logic [31:0] hist[$];
  logic [31:0] mOut = 0, mOe = 0, mRise = 0, mFall = 0, mPend = 0;

  function automatic logic [31:0] modelRead(logic [7:0] a);
    case (a)
      8'h00:   return hist[1];
      8'h04:   return mOe;
      8'h0C:   return mPend;
      8'h28:   return mRise;
      8'h2C:   return mFall;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagOf(logic [7:0] a);
    case (a)
      8'h00:        return "R2";
      8'h04:        return "R4";
      8'h0C:        return "R7";
      8'h28, 8'h2C: return "R5";
      default:      return "R1";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    hist = {32'h0, 32'h0, 32'h0, 32'h0};
  end

  always @(posedge clk) begin
    if (!rstN) begin
      hist = {32'h0, 32'h0, 32'h0, 32'h0};
      mOut = 0; mOe = 0; mRise = 0; mFall = 0; mPend = 0;
    end else begin
      logic [31:0] rs, fl, np;
      logic        w;
      rs = hist[1] & ~hist[2];
      fl = ~hist[1] & hist[2];
      w  = busSel && busWrite;
      np = mPend;
      if (w && busAddr == 8'h0C) np = np & ~busWdata;
      np = np | (rs & mRise) | (fl & mFall);
      if (w) begin
        case (busAddr)
          8'h14: mOut  = mOut | busWdata;
          8'h18: mOut  = mOut & ~busWdata;
          8'h1C: mOe   = mOe | busWdata;
          8'h20: mOe   = mOe & ~busWdata;
          8'h28: mRise = busWdata;
          8'h2C: mFall = busWdata;
          default: ;
        endcase
      end
      mPend = np;
      hist.push_front(padIn);
      void'(hist.pop_back());
    end
    #5;
    check("R3 padOut", padOut, mOut);
    check("R4 padOe", padOe, mOe);
    check("R8 irqOut", {31'h0, irqOut}, {31'h0, (mPend != 0)});
    check({tagOf(busAddr), " rdata"}, busRdata, busSel ? modelRead(busAddr) : 32'h0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    @(negedge clk);
    busSel = 0; busWrite = 0;
    @(posedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(posedge clk);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1; busWrite = 0; busAddr = a;
    #5 d = busRdata;
    @(posedge clk);
  endtask

  task automatic setPad(logic [31:0] v);
    @(negedge clk);
    busSel = 0; busWrite = 0; padIn = v;
    @(posedge clk);
  endtask

  // ---------------- directed and random sequences ----------------
  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    check("R10 padOut reset", padOut, 32'h0);
    check("R10 padOe reset", padOe, 32'h0);
    rd(8'h0C, r); check("R10 pend reset", r, 32'h0);
    rd(8'h28, r); check("R10 rise reset", r, 32'h0);

    // R3/R4 set and clear aliases, ignored writes
    wr(8'h14, 32'hA5A5_0003);
    wr(8'h18, 32'h0000_0001);
    idle(); check("R3 out set/clr", padOut, 32'hA5A5_0002);
    wr(8'h1C, 32'hFFFF_0000);
    wr(8'h20, 32'h00F0_0000);
    wr(8'h04, 32'h0000_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h04, r); check("R4 oe readback", r, 32'hFF0F_0000);
    rd(8'h30, r); check("R1 unmapped read", r, 32'h0);

    // R2 synchronized input, including bit 31
    setPad(32'h8000_00FF);
    idle();
    rd(8'h00, r); check("R2 input value", r, 32'h8000_00FF);

    // R5/R6: rise on 0..3, fall on 2..5, both on 2..3
    wr(8'h28, 32'h0000_000F);
    wr(8'h2C, 32'h0000_003C);
    wr(8'h0C, 32'hFFFF_FFFF);
    setPad(32'h0000_00F0);
    repeat (3) idle();
    rd(8'h0C, r); check("R6 fall edges 2,3", r, 32'h0000_000C);
    setPad(32'h0000_00FF);
    repeat (3) idle();
    rd(8'h0C, r); check("R6 rise edges 0..3", r, 32'h0000_000F);
    check("R8 irq high", {31'h0, irqOut}, 32'h1);

    // R7 partial clear
    wr(8'h0C, 32'h0000_0005);
    rd(8'h0C, r); check("R7 partial clear", r, 32'h0000_000A);

    // R11 steady level: clear all, hold pads, nothing returns
    wr(8'h0C, 32'hFFFF_FFFF);
    repeat (4) idle();
    rd(8'h0C, r); check("R11 steady level", r, 32'h0);
    check("R8 irq low", {31'h0, irqOut}, 32'h0);

    // R9 clear on the very cycle the edge lands
    setPad(32'h0000_00FE);  // bit0 falls; fall enable off for bit0
    setPad(32'h0000_00FF);  // bit0 rises, sampled at this edge
    idle();
    wr(8'h0C, 32'h0000_0001);
    rd(8'h0C, r); check("R9 edge beats clear", r, 32'h0000_0001);
    wr(8'h0C, 32'h0000_0001);

    // Random phase, checked against the model every clock
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] adr;
      case ($urandom_range(0, 10))
        0: adr = 8'h00; 1: adr = 8'h04; 2: adr = 8'h0C; 3: adr = 8'h14;
        4: adr = 8'h18; 5: adr = 8'h1C; 6: adr = 8'h20; 7: adr = 8'h28;
        8: adr = 8'h2C; 9: adr = 8'h08; default: adr = 8'h30;
      endcase
      @(negedge clk);
      busSel   = ($urandom_range(0, 3) != 0);
      busWrite = $urandom_range(0, 1);
      busAddr  = adr;
      busWdata = $urandom();
      if ($urandom_range(0, 2) == 0) padIn = padIn ^ $urandom();
      @(posedge clk);
    end
    idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule